// File: doc/BRIEF.md
# Parallel Scan Self-Test Sequencer

This block runs a logic self-test over a set of equal-length parallel scan chains. A single 32-bit pseudo-random generator drives every chain through an XOR spreading network, so neighbouring chains never receive delayed copies of the same bit stream. Each test pattern is shifted in over CHAIN_LEN cycles. One functional capture cycle follows. The captured response is then shifted out while the next pattern is shifted in.

Every bit leaving the chains is folded into a multiple-input signature register. That register has one stage per chain, so its width is NUM_CHAINS, not the number of observed flops. After the requested number of patterns, one extra shift pass drains the last response. The sequencer then raises `done` and holds the signature, which the surrounding test logic compares against a known-good value.

Top module: `scan_bist_ctrl`

## Requirements
- R1: A one-cycle `start` pulse is accepted in any state, including in the middle of a run, and restarts the run cleanly. It loads the generator with SEED (default 32'h1D872B41), clears the signature and all counters, and samples `pattern_count`. Shifting begins in the next cycle.
- R2: Every shift pass lasts exactly CHAIN_LEN consecutive cycles. In each of these cycles `scan_en` is 1 and `capture` is 0.
- R3: Between two shift passes there is exactly one cycle with `capture` at 1 and `scan_en` at 0. The two strobes are never both at 1.
- R4: With N = `pattern_count` as sampled at start, a run has N capture cycles and N+1 shift passes. `done` rises after CHAIN_LEN*(N+1)+N active cycles and stays at 1 until the next start.
- R5: The generator state s advances only in shift cycles, by the rule s <= {s[30:0], s[31]^s[21]^s[1]^s[0]}. It is never zero.
- R6: In every shift cycle, `chain_in[c]` equals s[c mod 32] ^ s[(7c+3) mod 32] ^ s[(13c+10) mod 32], computed from the current generator state.
- R7: The signature m has NUM_CHAINS bits. In each shift cycle except those of the first pass, m[i] becomes m[i-1] ^ `chain_out[i]` ^ (POLY[i] & m[NUM_CHAINS-1]), where m[-1] is 0 and POLY by default has only bits 0 and 3 set. Chain contents present before the first pass therefore do not affect the signature.
- R8: `signature` holds its value in capture cycles and, while `done` is 1, stays constant.
- R9: With `pattern_count` equal to 0, the run is a single shift pass with no capture. It ends with a signature of 0.
- R10: After reset, `scan_en`, `capture` and `done` are 0 and `signature` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a run |
| pattern_count | input | PAT_W | Number of patterns to apply, sampled at start |
| chain_out | input | NUM_CHAINS | Serial outputs of the scan chains |
| chain_in | output | NUM_CHAINS | Serial inputs to the scan chains |
| scan_en | output | 1 | Chains shift when 1 |
| capture | output | 1 | Functional capture strobe |
| done | output | 1 | Run complete, signature valid |
| signature | output | NUM_CHAINS | Compacted response |

## Verification
In every shift cycle after the first pass, two things happen at once: the response of pattern k is compacted while pattern k+1 is loaded. The bench provokes this with random pattern counts and random capture functions in a chain model. It also fills the chains with garbage before each run, so that compaction during the first pass would corrupt the result. It judges the outcome by comparing the final signature with a bench reference that steps generator, chains and compactor bit by bit. It also checks that each run ends exactly at CHAIN_LEN*(N+1)+N cycles, which only holds if load and unload share the same passes.

// File: rtl/scan_bist_pkg.sv
package scan_bist_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_CAPT  = 2'd2,
    ST_DONE  = 2'd3
  } bist_state_e;
endpackage

// File: rtl/bist_lfsr_src.sv
module bist_lfsr_src #(
  parameter int          LFSR_W     = 32,
  parameter int          NUM_CHAINS = 25,
  parameter logic [31:0] TAPS       = 32'h8020_0003,
  parameter logic [31:0] SEED       = 32'h1D87_2B41
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  seed_load,
  input  logic                  step,
  output logic [NUM_CHAINS-1:0] chain_in
);
  logic [LFSR_W-1:0] s_q;
  logic              fb;

  assign fb = ^(s_q & TAPS[LFSR_W-1:0]);

  always_ff @(posedge clk) begin
    if (rst || seed_load) s_q <= SEED[LFSR_W-1:0];
    else if (step)        s_q <= {s_q[LFSR_W-2:0], fb};
  end

  // Each chain input mixes three distinct generator stages.
  for (genvar c = 0; c < NUM_CHAINS; c++) begin : g_phase
    localparam int TA = c % LFSR_W;
    localparam int TB = (7 * c + 3) % LFSR_W;
    localparam int TC = (13 * c + 10) % LFSR_W;
    assign chain_in[c] = s_q[TA] ^ s_q[TB] ^ s_q[TC];
  end

  // R5
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (rst) s_q != '0);
  // R5
  lfsr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!step && !seed_load) |=> $stable(s_q));
endmodule

// File: rtl/bist_misr.sv
module bist_misr #(
  parameter int             W    = 25,
  parameter logic [W-1:0]   POLY = W'(9)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         en,
  input  logic [W-1:0] din,
  output logic [W-1:0] sig
);
  logic [W-1:0] m_q;
  logic [W-1:0] m_next;

  always_comb begin
    m_next = {m_q[W-2:0], 1'b0} ^ din;
    if (m_q[W-1]) m_next = m_next ^ POLY;
  end

  always_ff @(posedge clk) begin
    if (rst || clear) m_q <= '0;
    else if (en)      m_q <= m_next;
  end

  assign sig = m_q;

  // R7
  misr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!en && !clear) |=> $stable(m_q));
  // R1
  misr_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clear |=> (m_q == '0));
endmodule

// File: rtl/bist_seq.sv
module bist_seq
  import scan_bist_pkg::*;
#(
  parameter int CHAIN_LEN = 200,
  parameter int PAT_W     = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [PAT_W-1:0] pattern_count,
  output logic             scan_en,
  output logic             capture,
  output logic             done,
  output logic             misr_en,
  output logic             misr_clr,
  output logic             lfsr_load,
  output logic             lfsr_step
);
  localparam int CNT_W = (CHAIN_LEN > 1) ? $clog2(CHAIN_LEN) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CHAIN_LEN - 1);

  bist_state_e      state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [PAT_W-1:0] pass_q;
  logic [PAT_W-1:0] npat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      pass_q  <= '0;
      npat_q  <= '0;
    end else if (start) begin
      state_q <= ST_SHIFT;
      cnt_q   <= '0;
      pass_q  <= '0;
      npat_q  <= pattern_count;
    end else begin
      case (state_q)
        ST_SHIFT: begin
          if (cnt_q == LAST) begin
            cnt_q   <= '0;
            state_q <= (pass_q == npat_q) ? ST_DONE : ST_CAPT;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_CAPT: begin
          pass_q  <= pass_q + 1'b1;
          state_q <= ST_SHIFT;
        end
        default: state_q <= state_q;
      endcase
    end
  end

  assign scan_en   = (state_q == ST_SHIFT);
  assign capture   = (state_q == ST_CAPT);
  assign done      = (state_q == ST_DONE);
  assign misr_en   = (state_q == ST_SHIFT) && (pass_q != '0);
  assign misr_clr  = start;
  assign lfsr_load = start;
  assign lfsr_step = (state_q == ST_SHIFT);

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);
  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(scan_en && capture));
  // R3
  capture_single_chk: assert property (@(posedge clk) disable iff (rst)
    capture |=> (scan_en && !capture));
  // R4
  pass_bound_chk: assert property (@(posedge clk) disable iff (rst)
    pass_q <= npat_q);
  // R4
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done);
endmodule

// File: rtl/scan_bist_ctrl.sv
module scan_bist_ctrl #(
  parameter int                   NUM_CHAINS = 25,
  parameter int                   CHAIN_LEN  = 200,
  parameter int                   PAT_W      = 8,
  parameter int                   LFSR_W     = 32,
  parameter logic [31:0]          SEED       = 32'h1D87_2B41,
  parameter logic [NUM_CHAINS-1:0] POLY      = NUM_CHAINS'(9)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic [PAT_W-1:0]      pattern_count,
  input  logic [NUM_CHAINS-1:0] chain_out,
  output logic [NUM_CHAINS-1:0] chain_in,
  output logic                  scan_en,
  output logic                  capture,
  output logic                  done,
  output logic [NUM_CHAINS-1:0] signature
);
  logic misr_en, misr_clr, lfsr_load, lfsr_step;

  bist_seq #(.CHAIN_LEN(CHAIN_LEN), .PAT_W(PAT_W)) u_seq (
    .clk(clk), .rst(rst), .start(start), .pattern_count(pattern_count),
    .scan_en(scan_en), .capture(capture), .done(done),
    .misr_en(misr_en), .misr_clr(misr_clr),
    .lfsr_load(lfsr_load), .lfsr_step(lfsr_step)
  );

  bist_lfsr_src #(.LFSR_W(LFSR_W), .NUM_CHAINS(NUM_CHAINS), .SEED(SEED)) u_src (
    .clk(clk), .rst(rst), .seed_load(lfsr_load), .step(lfsr_step),
    .chain_in(chain_in)
  );

  bist_misr #(.W(NUM_CHAINS), .POLY(POLY)) u_misr (
    .clk(clk), .rst(rst), .clear(misr_clr), .en(misr_en),
    .din(chain_out), .sig(signature)
  );

  // R8
  sig_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> $stable(signature));
  // R8
  sig_capt_chk: assert property (@(posedge clk) disable iff (rst)
    (capture && !start) |=> $stable(signature));
endmodule

// File: tb/scan_bist_ctrl_tb_top.sv
module scan_bist_ctrl_tb_top;
  localparam int C = 25;
  localparam int L = 200;
  localparam int PW = 8;
  localparam logic [31:0] SEED = 32'h1D87_2B41;
  localparam logic [C-1:0] POLY = C'(9);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [PW-1:0] pattern_count = '0;
  logic [C-1:0] chain_out, chain_in, signature;
  logic scan_en, capture, done;

  logic [L-1:0] chain_q [C];
  logic [31:0]  cap_mask = '0;
  logic         scramble = 1'b0;

  int checks = 0;
  int fails  = 0;

  always #10ns clk = ~clk;

  scan_bist_ctrl dut_i (
    .clk(clk), .rst(rst), .start(start), .pattern_count(pattern_count),
    .chain_out(chain_out), .chain_in(chain_in), .scan_en(scan_en),
    .capture(capture), .done(done), .signature(signature)
  );

  for (genvar c = 0; c < C; c++) begin : g_out
    assign chain_out[c] = chain_q[c][L-1];
  end

  // Chain model: shift registers around a simple capture function.
  always @(posedge clk) begin
    for (int c = 0; c < C; c++) begin
      if (scramble) begin
        for (int i = 0; i < L; i++) chain_q[c][i] <= 1'($urandom);
      end else if (scan_en) begin
        chain_q[c] <= {chain_q[c][L-2:0], chain_in[c]};
      end else if (capture) begin
        for (int i = 0; i < L; i++)
          chain_q[c][i] <= chain_q[c][i] ^ chain_q[(c+1)%C][(i+1)%L] ^ cap_mask[(c+i)%32];
      end
    end
  end

  function automatic logic [31:0] lfsr_next(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  function automatic logic [C-1:0] spread(input logic [31:0] s);
    logic [C-1:0] r;
    for (int c = 0; c < C; c++) r[c] = s[c%32] ^ s[(7*c+3)%32] ^ s[(13*c+10)%32];
    return r;
  endfunction

  function automatic logic [C-1:0] misr_next(input logic [C-1:0] m, input logic [C-1:0] d);
    logic [C-1:0] r;
    for (int i = 0; i < C; i++)
      r[i] = (i == 0 ? 1'b0 : m[i-1]) ^ d[i] ^ (POLY[i] & m[C-1]);
    return r;
  endfunction

  task automatic ref_sig(input int n, input logic [31:0] mask, output logic [C-1:0] sig);
    logic [L-1:0] ch [C];
    logic [L-1:0] nw [C];
    logic [31:0]  lf;
    logic [C-1:0] outs, ins;
    lf = SEED;
    sig = '0;
    for (int c = 0; c < C; c++) ch[c] = '0;
    for (int p = 0; p <= n; p++) begin
      for (int k = 0; k < L; k++) begin
        for (int c = 0; c < C; c++) outs[c] = ch[c][L-1];
        if (p > 0) sig = misr_next(sig, outs);
        ins = spread(lf);
        for (int c = 0; c < C; c++) ch[c] = {ch[c][L-2:0], ins[c]};
        lf = lfsr_next(lf);
      end
      if (p < n) begin
        for (int c = 0; c < C; c++)
          for (int i = 0; i < L; i++)
            nw[c][i] = ch[c][i] ^ ch[(c+1)%C][(i+1)%L] ^ mask[(c+i)%32];
        for (int c = 0; c < C; c++) ch[c] = nw[c];
      end
    end
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic garbage();
    @(negedge clk) scramble = 1'b1;
    @(negedge clk) scramble = 1'b0;
  endtask

  task automatic run_and_check(input int n, input logic [31:0] mask);
    logic [31:0]  lf;
    logic [C-1:0] exp_sig, held;
    int cyc, run, caps, bad_in, limit;
    bit broke;
    ref_sig(n, mask, exp_sig);
    @(negedge clk);
    pattern_count = PW'(n);
    cap_mask = mask;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    pattern_count = PW'($urandom);
    // R1: shifting starts one cycle after start with the seeded generator
    check(scan_en && chain_in == spread(SEED), "R1", "first shift cycle",
          {63'd0, scan_en}, 64'd1);
    lf = SEED; cyc = 1; run = 0; caps = 0; bad_in = 0; broke = 0;
    limit = L * (n + 1) + n + 10;
    while (!done) begin
      if (scan_en) begin
        if (chain_in != spread(lf)) bad_in++;
        lf = lfsr_next(lf);
        run++;
      end
      if (capture) begin
        // R2: pass length
        check(run == L, "R2", "shift pass length", 64'(run), 64'(L));
        // R3: capture excludes scan_en
        check(!scan_en, "R3", "strobe overlap", 64'(scan_en), 64'd0);
        caps++;
        run = 0;
      end
      if (cyc > limit) begin broke = 1; break; end
      @(negedge clk);
      cyc++;
    end
    // R4 timing and capture count
    check(!broke && cyc == L * (n + 1) + n + 1, "R4", "done cycle",
          64'(cyc), 64'(L * (n + 1) + n + 1));
    check(caps == n, "R4", "capture count", 64'(caps), 64'(n));
    check(run == L, "R2", "final pass length", 64'(run), 64'(L));
    // R5 R6: per-cycle chain inputs follow the spread generator
    check(bad_in == 0, "R6", "chain_in mismatches", 64'(bad_in), 64'd0);
    // R7 (R9 when n is 0): signature against reference
    check(signature == exp_sig, n == 0 ? "R9" : "R7", "signature",
          64'(signature), 64'(exp_sig));
    held = signature;
    repeat (5) @(negedge clk);
    // R8
    check(done && signature == held, "R8", "signature held after done",
          64'(signature), 64'(held));
  endtask

  initial begin
    #(20ns * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check(!scan_en && !capture && !done && signature == '0, "R10", "reset outputs",
          {61'd0, scan_en, capture, done}, 64'd0);
    check(chain_in == spread(SEED), "R5", "seeded generator after reset",
          64'(chain_in), 64'(spread(SEED)));

    // R9: zero patterns
    garbage();
    run_and_check(0, 32'h0);
    // directed: single pattern, then a longer run
    garbage();
    run_and_check(1, 32'hFFFF_FFFF);
    garbage();
    run_and_check(4, 32'h0F0F_3C3C);

    // random runs; garbage checks that the first pass is not compacted (R7)
    for (int r = 0; r < 6; r++) begin
      garbage();
      run_and_check(1 + int'($urandom_range(3)), $urandom);
    end

    // R1: restart in the middle of a run
    @(negedge clk);
    pattern_count = PW'(3);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (317) @(negedge clk);
    check(!done, "R1", "run still active before restart", 64'(done), 64'd0);
    run_and_check(2, 32'hA5A5_5A5A);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule